// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog whose down-counter runs on its own slow clock, apart from the bus clock that software uses. Software reaches it through four word locations on a plain write/read strobe interface: a key location, a divider-code location, a reload location and a status location. Magic key values do three things. One opens the two configuration locations for writing. One reloads the counter. One starts the counter, and once started it cannot be stopped.

A new divider code or reload value is captured on the bus side. It is then handed across to the counter clock through a toggle handshake. While a hand-over is in flight, a per-register busy flag in the status word stays set, and further writes to that register are dropped. When the running counter runs out, the block pulses a reset request for one slow-clock cycle. It then reloads and keeps counting, so a system that keeps running sees one request per timeout.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, the divider code reads 0, the reload reads 0xFFF, the status reads 0 and `rst_req` is low.
- R2: Locations are selected by `wr_sel`/`rd_sel`: 0 key, 1 divider code (bits 2:0), 2 reload (bits 11:0), 3 status. Writes to locations 1 and 2 take effect and read back only after the key 0x5555 has been written; otherwise they are ignored.
- R3: Any key write other than 0x5555 closes write access, including the refresh key 0xAAAA.
- R4: An accepted divider write sets status bit 0, and an accepted reload write sets status bit 1. Each bit stays set until its value has reached the counter domain, and clears within 4 counter-clock periods plus 3 bus-clock cycles. Status reads 0 when nothing is pending.
- R5: A write to a configuration location whose status bit is still set is ignored.
- R6: Divider code k gives one counter tick every 4·2^k counter-clock cycles, saturating at 256 for codes 6 and 7.
- R7: No reset request is raised before the key 0xCCCC has been written. After it has been written, no other key value stops the counter.
- R8: Key 0xAAAA loads the counter with the reload value R. R ticks later `rst_req` is high for exactly one counter-clock cycle. The counter then reloads, so later requests come every R·divide counter-clock cycles.
- R9: A refresh wins over an expiry in the same cycle, and refreshes issued more often than the timeout keep `rst_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| cnt_clk | input | 1 | Slow counter clock |
| rst_n | input | 1 | Synchronous active-low reset, seen in both clock domains |
| wr_en | input | 1 | Write strobe, one bus cycle per write |
| wr_sel | input | 2 | Location written |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Location read |
| rd_data | output | 16 | Read data for `rd_sel`, combinational |
| rst_req | output | 1 | Reset request, one counter-clock cycle wide, in the counter domain |

## Verification
A wrong access flag or a wrong busy flag shows at the next read of a configuration location or of the status word. That is one bus cycle after the write that disturbed it. A wrong divider ratio, reload capture or expiry decrement only shows at `rst_req`. It appears as a request that comes early or late against the expected count of counter-clock cycles. The interval between two consecutive requests is compared exactly, so an error of a single tick is caught on the second timeout after configuration. A stop or a missing start shows as requests that are absent, or present, over a window several timeouts long.

// File: rtl/keyed_wdog_pkg.sv
// Shared constants for the keyed watchdog: key codes, location map, widths.
// Assumes a 16-bit data path on the register strobe interface.
package keyed_wdog_pkg;
    localparam int DATA_W = 16;
    localparam int SEL_W  = 2;

    localparam logic [DATA_W-1:0] KEY_OPEN    = 16'h5555;
    localparam logic [DATA_W-1:0] KEY_REFRESH = 16'hAAAA;
    localparam logic [DATA_W-1:0] KEY_START   = 16'hCCCC;

    typedef enum logic [SEL_W-1:0] {
        LOC_KEY  = 2'd0,
        LOC_DIV  = 2'd1,
        LOC_RLD  = 2'd2,
        LOC_STAT = 2'd3
    } loc_t;
endpackage

// File: rtl/keyed_wdog_cfg_cdc.sv
// Carries one configuration value from the bus clock into the counter clock.
// A toggle handshake moves it across. The source holds a shadow copy that is
// readable on the bus side. busy is high from the load until the destination
// has acknowledged. Assumes the caller never asserts load while busy is high.
module keyed_wdog_cfg_cdc #(
    parameter int          W       = 12,
    parameter logic [W-1:0] RST_VAL = '0,
    parameter int          SYNC    = 2
) (
    input  logic         clk,
    input  logic         cnt_clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] shadow,
    output logic         busy,
    output logic [W-1:0] dst_q
);
    logic            req_q;
    logic            done_q;
    logic [SYNC-1:0] req_s;
    logic [SYNC-1:0] ack_s;

    // Bus side: capture the new value and flip the request toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= RST_VAL;
            req_q  <= 1'b0;
        end else if (load) begin
            shadow <= din;
            req_q  <= ~req_q;
        end
    end

    // Bus side: bring the acknowledge toggle back from the counter domain.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_s <= '0;
        else        ack_s <= {ack_s[SYNC-2:0], done_q};
    end

    assign busy = req_q ^ ack_s[SYNC-1];

    // Counter side: synchronise the request toggle.
    always_ff @(posedge cnt_clk) begin
        if (!rst_n) req_s <= '0;
        else        req_s <= {req_s[SYNC-2:0], req_q};
    end

    // Counter side: on a new request, copy the held value and acknowledge.
    always_ff @(posedge cnt_clk) begin
        if (!rst_n) begin
            dst_q  <= RST_VAL;
            done_q <= 1'b0;
        end else if (req_s[SYNC-1] != done_q) begin
            dst_q  <= shadow;
            done_q <= req_s[SYNC-1];
        end
    end
endmodule

// File: rtl/keyed_wdog_evt_cdc.sv
// Turns a one-cycle bus-clock event into a one-cycle counter-clock pulse.
// Assumes events are spaced further apart than the synchroniser latency.
module keyed_wdog_evt_cdc #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic cnt_clk,
    input  logic rst_n,
    input  logic evt,
    output logic pulse
);
    logic          tog_q;
    logic [SYNC:0] sync_q;

    // Bus side: each event flips the toggle.
    always_ff @(posedge clk) begin
        if (!rst_n)   tog_q <= 1'b0;
        else if (evt) tog_q <= ~tog_q;
    end

    // Counter side: synchronise the toggle and keep one extra stage for edge detection.
    always_ff @(posedge cnt_clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC-1:0], tog_q};
    end

    assign pulse = sync_q[SYNC] ^ sync_q[SYNC-1];
endmodule

// File: rtl/keyed_wdog_core.sv
// Counter-domain core: a prescaler of 2^(MIN_DIV_LOG + code) clocks, capped at
// 2^MAX_DIV_LOG, and a down-counter that raises a one-cycle request on expiry
// and reloads. A refresh loads the reload value, restarts the prescaler and
// wins over an expiry in the same cycle. Once started, it counts until reset.
module keyed_wdog_core #(
    parameter int              PRE_W       = 3,
    parameter int              RLD_W       = 12,
    parameter int              MIN_DIV_LOG = 2,
    parameter int              MAX_DIV_LOG = 8,
    parameter logic [RLD_W-1:0] RLD_RST    = '1
) (
    input  logic             cnt_clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] pre_code,
    input  logic [RLD_W-1:0] rld_val,
    input  logic             refresh,
    input  logic             start,
    output logic             running,
    output logic             rst_req
);
    localparam int DIV_W = MAX_DIV_LOG;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_lim;
    logic [RLD_W-1:0] cnt_q;
    logic             tick;
    logic             expire;

    // Terminal count of the prescaler for the current code.
    always_comb begin
        int sh;
        sh = int'(pre_code) + MIN_DIV_LOG;
        if (sh > MAX_DIV_LOG) sh = MAX_DIV_LOG;
        div_lim = DIV_W'((1 << sh) - 1);
    end

    assign tick   = running && (div_q == div_lim);
    assign expire = tick && (cnt_q == '0 || cnt_q == RLD_W'(1));

    // Sticky run flag: set by the start event, cleared only by reset.
    always_ff @(posedge cnt_clk) begin
        if (!rst_n)     running <= 1'b0;
        else if (start) running <= 1'b1;
    end

    // Prescaler: restarted by a refresh, free-running while the watchdog runs.
    always_ff @(posedge cnt_clk) begin
        if (!rst_n)        div_q <= '0;
        else if (refresh)  div_q <= '0;
        else if (tick)     div_q <= '0;
        else if (running)  div_q <= div_q + DIV_W'(1);
    end

    // Down-counter and reset request; refresh takes priority over expiry.
    always_ff @(posedge cnt_clk) begin
        if (!rst_n) begin
            cnt_q   <= RLD_RST;
            rst_req <= 1'b0;
        end else if (refresh) begin
            cnt_q   <= rld_val;
            rst_req <= 1'b0;
        end else if (expire) begin
            cnt_q   <= rld_val;
            rst_req <= 1'b1;
        end else begin
            rst_req <= 1'b0;
            if (tick) cnt_q <= cnt_q - RLD_W'(1);
        end
    end
endmodule

// File: rtl/keyed_wdog.sv
// Top of the keyed watchdog. Bus side: key decoding, the write-access latch,
// acceptance of configuration writes and the read multiplexer. Configuration
// values and key events cross into the counter clock through the CDC helpers.
// Assumes one write per wr_en cycle and a reset that lasts several counter-clock
// periods, so that both domains see it.
module keyed_wdog #(
    parameter int PRE_W       = 3,
    parameter int RLD_W       = 12,
    parameter int MIN_DIV_LOG = 2,
    parameter int MAX_DIV_LOG = 8,
    parameter int SYNC        = 2
) (
    input  logic        clk,
    input  logic        cnt_clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [15:0] wr_data,
    input  logic [1:0]  rd_sel,
    output logic [15:0] rd_data,
    output logic        rst_req
);
    import keyed_wdog_pkg::*;

    localparam logic [RLD_W-1:0] RLD_RST = '1;
    localparam logic [PRE_W-1:0] PRE_RST = '0;

    logic             access_q;
    logic             key_wr;
    logic             pre_load;
    logic             rld_load;
    logic             refresh_evt;
    logic             start_evt;
    logic [PRE_W-1:0] pre_shadow;
    logic [RLD_W-1:0] rld_shadow;
    logic             pre_busy;
    logic             rld_busy;
    logic [PRE_W-1:0] pre_cnt;
    logic [RLD_W-1:0] rld_cnt;
    logic             refresh_s;
    logic             start_s;
    logic             cnt_running;

    assign key_wr      = wr_en && (wr_sel == LOC_KEY);
    assign refresh_evt = key_wr && (wr_data == KEY_REFRESH);
    assign start_evt   = key_wr && (wr_data == KEY_START);
    assign pre_load    = wr_en && (wr_sel == LOC_DIV) && access_q && !pre_busy;
    assign rld_load    = wr_en && (wr_sel == LOC_RLD) && access_q && !rld_busy;

    // Write-access latch: opened by the open key, closed by any other key.
    always_ff @(posedge clk) begin
        if (!rst_n)      access_q <= 1'b0;
        else if (key_wr) access_q <= (wr_data == KEY_OPEN);
    end

    keyed_wdog_cfg_cdc #(.W(PRE_W), .RST_VAL(PRE_RST), .SYNC(SYNC)) pre_cdc_i (
        .clk(clk), .cnt_clk(cnt_clk), .rst_n(rst_n),
        .load(pre_load), .din(wr_data[PRE_W-1:0]),
        .shadow(pre_shadow), .busy(pre_busy), .dst_q(pre_cnt)
    );

    keyed_wdog_cfg_cdc #(.W(RLD_W), .RST_VAL(RLD_RST), .SYNC(SYNC)) rld_cdc_i (
        .clk(clk), .cnt_clk(cnt_clk), .rst_n(rst_n),
        .load(rld_load), .din(wr_data[RLD_W-1:0]),
        .shadow(rld_shadow), .busy(rld_busy), .dst_q(rld_cnt)
    );

    keyed_wdog_evt_cdc #(.SYNC(SYNC)) refresh_cdc_i (
        .clk(clk), .cnt_clk(cnt_clk), .rst_n(rst_n),
        .evt(refresh_evt), .pulse(refresh_s)
    );

    keyed_wdog_evt_cdc #(.SYNC(SYNC)) start_cdc_i (
        .clk(clk), .cnt_clk(cnt_clk), .rst_n(rst_n),
        .evt(start_evt), .pulse(start_s)
    );

    keyed_wdog_core #(
        .PRE_W(PRE_W), .RLD_W(RLD_W),
        .MIN_DIV_LOG(MIN_DIV_LOG), .MAX_DIV_LOG(MAX_DIV_LOG), .RLD_RST(RLD_RST)
    ) core_i (
        .cnt_clk(cnt_clk), .rst_n(rst_n),
        .pre_code(pre_cnt), .rld_val(rld_cnt),
        .refresh(refresh_s), .start(start_s),
        .running(cnt_running), .rst_req(rst_req)
    );

    // Read multiplexer; the key location reads as zero.
    always_comb begin
        rd_data = '0;
        case (rd_sel)
            LOC_DIV:  rd_data = 16'(pre_shadow);
            LOC_RLD:  rd_data = 16'(rld_shadow);
            LOC_STAT: rd_data = {14'd0, rld_busy, pre_busy};
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/keyed_wdog_chk.sv
// Property checker for the keyed watchdog, bound into the top module.
// Bus-domain properties use clk; counter-domain properties use cnt_clk.
module keyed_wdog_chk (
    input logic       clk,
    input logic       cnt_clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] wr_sel,
    input logic       access,
    input logic       pre_busy,
    input logic [2:0] pre_shadow,
    input logic       run,
    input logic       refresh_pulse,
    input logic       rst_req
);
    // R2
    locked_div_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1 && !access) |=> $stable(pre_shadow));

    // R4
    div_busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1 && access && !pre_busy) |=> pre_busy);

    // R5
    busy_div_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1 && pre_busy) |=> $stable(pre_shadow));

    // R7
    run_sticky_chk: assert property (@(posedge cnt_clk) disable iff (!rst_n)
        run |=> run);

    // R7
    req_needs_run_chk: assert property (@(posedge cnt_clk) disable iff (!rst_n)
        rst_req |-> run);

    // R8
    req_one_cycle_chk: assert property (@(posedge cnt_clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R9
    refresh_wins_chk: assert property (@(posedge cnt_clk) disable iff (!rst_n)
        refresh_pulse |=> !rst_req);
endmodule

bind keyed_wdog keyed_wdog_chk chk_i (
    .clk(clk), .cnt_clk(cnt_clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_sel(wr_sel),
    .access(access_q), .pre_busy(pre_busy), .pre_shadow(pre_shadow),
    .run(cnt_running), .refresh_pulse(refresh_s), .rst_req(rst_req)
);

// File: tb/keyed_wdog_tb_top.sv
// Self-checking bench: directed corner cases plus seeded random configurations.
module keyed_wdog_tb_top;
    logic        clk = 1'b0;
    logic        cnt_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [1:0]  rd_sel = 2'd0;
    logic [15:0] rd_data;
    logic        rst_req;

    int checks = 0;
    int errors = 0;
    int scyc = 0;
    int pulse_cnt = 0;
    int last_pulse = 0;
    int bus_cyc = 0;
    logic prev_req = 1'b0;

    always #2.5 clk = ~clk;
    always #20  cnt_clk = ~cnt_clk;

    keyed_wdog dut_i (
        .clk(clk), .cnt_clk(cnt_clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .rst_req(rst_req)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int ratio(input int k);
        int s;
        s = k + 2;
        if (s > 8) s = 8;
        return 1 << s;
    endfunction

    // Counter-domain monitor: cycle count, pulse log, pulse-width check (R8).
    always @(negedge cnt_clk) begin
        scyc++;
        if (rst_n && prev_req) check(!rst_req, "R8 pulse width", int'(rst_req), 0);
        if (rst_n && rst_req) begin
            pulse_cnt++;
            last_pulse = scyc;
        end
        prev_req = rst_req;
    end

    // Watchdog on the whole run.
    always @(posedge clk) begin
        bus_cyc++;
        if (bus_cyc > 190000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", bus_cyc, 190000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [15:0] d);
        rd_sel = sel;
        #1;
        d = rd_data;
    endtask

    task automatic wait_idle(output int n);
        logic [15:0] s;
        n = 0;
        rd(2'd3, s);
        while (s != 16'd0) begin
            @(negedge clk);
            n++;
            rd(2'd3, s);
        end
    endtask

    task automatic wait_pulses(input int n);
        while (pulse_cnt < n) @(negedge cnt_clk);
    endtask

    task automatic setup(input int k, input int r);
        int n;
        wr(2'd0, 16'hAAAA);
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'(k));
        wr(2'd2, 16'(r));
        wait_idle(n);
    endtask

    // Refresh, optionally start, then time the first and second expiry (R6, R8).
    task automatic measure(input int k, input int r, input bit do_start);
        int t0, pc0, t1, exp_p;
        setup(k, r);
        pc0 = pulse_cnt;
        t0 = scyc;
        wr(2'd0, 16'hAAAA);
        if (do_start) wr(2'd0, 16'hCCCC);
        exp_p = ratio(k) * r;
        wait_pulses(pc0 + 1);
        t1 = last_pulse;
        check((t1 - t0) >= exp_p && (t1 - t0) <= exp_p + 10, "R8 first expiry", t1 - t0, exp_p);
        wait_pulses(pc0 + 2);
        check((last_pulse - t1) == exp_p, "R6 expiry period", last_pulse - t1, exp_p);
    endtask

    initial begin
        logic [15:0] v;
        int n, pc;
        void'($urandom(32'd2024));
        repeat (40) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        rd(2'd1, v); check(v == 16'd0, "R1 divider reset", v, 0);
        rd(2'd2, v); check(v == 16'hFFF, "R1 reload reset", v, 16'hFFF);
        rd(2'd3, v); check(v == 16'd0, "R1 status reset", v, 0);
        check(rst_req == 1'b0, "R1 rst_req low", int'(rst_req), 0);

        // R2 locked writes ignored
        wr(2'd1, 16'd3);  rd(2'd1, v); check(v == 16'd0, "R2 locked divider", v, 0);
        wr(2'd2, 16'd5);  rd(2'd2, v); check(v == 16'hFFF, "R2 locked reload", v, 16'hFFF);
        rd(2'd3, v); check(v == 16'd0, "R2 locked status", v, 0);

        // R2/R4 open, write, busy flags
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'd2);
        rd(2'd3, v); check(v[0] == 1'b1, "R4 divider busy", v, 1);
        rd(2'd1, v); check(v == 16'd2, "R2 divider write", v, 2);
        wait_idle(n); check(n <= 35, "R4 divider busy clears", n, 35);
        wr(2'd2, 16'd20);
        rd(2'd3, v); check(v == 16'd2, "R4 reload busy", v, 2);
        rd(2'd2, v); check(v == 16'd20, "R2 reload write", v, 20);
        wait_idle(n); check(n <= 35, "R4 reload busy clears", n, 35);

        // R5 write while busy ignored
        wr(2'd1, 16'd5);
        wr(2'd1, 16'd6);
        wait_idle(n);
        rd(2'd1, v); check(v == 16'd5, "R5 busy write dropped", v, 5);

        // R3 other key closes access
        wr(2'd0, 16'h1234);
        wr(2'd2, 16'd7); rd(2'd2, v); check(v == 16'd20, "R3 other key locks", v, 20);
        wr(2'd0, 16'h5555);
        wr(2'd0, 16'hAAAA);
        wr(2'd1, 16'd1); rd(2'd1, v); check(v == 16'd5, "R3 refresh locks", v, 5);

        // R7 no request before start
        setup(0, 2);
        wr(2'd0, 16'hAAAA);
        repeat (100) @(negedge cnt_clk);
        check(pulse_cnt == 0, "R7 idle before start", pulse_cnt, 0);

        // R7/R8 start and first timeouts
        measure(0, 3, 1'b1);

        // R6/R8 random configurations
        for (int i = 0; i < 4; i++) begin
            int k, r;
            k = 1 + int'($urandom_range(2));
            r = 8 + int'($urandom_range(10));
            measure(k, r, 1'b0);
        end

        // R6 saturation of codes 6 and 7
        measure(6, 2, 1'b0);
        measure(7, 2, 1'b0);

        // R9 frequent refresh keeps request low
        setup(1, 16);
        wr(2'd0, 16'hAAAA);
        repeat (10) @(negedge cnt_clk);
        pc = pulse_cnt;
        for (int i = 0; i < 10; i++) begin
            wr(2'd0, 16'hAAAA);
            repeat (50) @(negedge cnt_clk);
        end
        check(pulse_cnt == pc, "R9 refresh holds off", pulse_cnt - pc, 0);

        // R7 other keys do not stop the counter
        wr(2'd0, 16'h0000);
        wr(2'd0, 16'hDEAD);
        repeat (300) @(negedge cnt_clk);
        check(pulse_cnt >= pc + 2, "R7 cannot stop", pulse_cnt - pc, 2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule